// File: doc/BRIEF.md
# Byte ALU with Packed Legacy Flags

This block is the arithmetic and logic unit of an 8-bit accumulator datapath. Each operation takes the accumulator, a second operand, the incoming flag byte and a 5-bit operation code. It returns a result byte, a new flag byte and a write-enable for the destination. A separate 16-bit path adds two register pairs. The block holds no register file and does no decimal adjust.

The logic is combinational. It is sampled into output registers on the rising clock edge where `op_valid` is high. Those registers hold until the next strobe, so the surrounding sequencer can read them at leisure. The flag byte always has the same packed layout: sign in bit 7, zero in bit 6, half carry in bit 4, parity in bit 2 and carry in bit 0. Bit 1 is always 1, and bits 3 and 5 are always 0.

Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 rotate left circular, 11 rotate right circular, 12 rotate left through carry, 13 rotate right through carry, 14 complement, 15 set carry, 16 complement carry, 17 pair add. Codes 18 to 31 are undefined.

Top module: `byte_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `res_out`=0x00, `pair_out`=0x0000, `flags_out`=0x02, `wr_en`=0 and `done`=0, even if `op_valid` is also high.
- R2: An operation is captured at the edge where `op_valid` is high. `done` is 1 for exactly the following cycle, and `wr_en` is high only in that cycle. While `op_valid` is low, `res_out` and `flags_out` hold their values.
- R3: Add (code 0) and add with carry (code 1, which adds carry-in bit 0) write A+B(+C) mod 256. Carry is set when the 9-bit sum exceeds 0xFF. Half carry is entry k of the table 0,0,1,0,1,0,1,1, where k = {A[3], B[3], result[3]}.
- R4: Subtract (code 2) and subtract with borrow (code 3) write A-B(-C) mod 256, and carry acts as the borrow. Half carry is the inverse of entry k of the table 0,1,1,1,0,0,0,1, with k formed as in R3.
- R5: Compare (code 4) produces the same flags as subtract, with `wr_en`=0 and `res_out` equal to the accumulator.
- R6: For every operation that updates them, sign = result bit 7, zero = (result==0), and parity = 1 when the result holds an even number of one bits.
- R7: AND (code 5) clears carry and sets half carry to A[3] OR B[3]. OR (code 6) and XOR (code 7) clear both carry and half carry.
- R8: Increment (code 8) and decrement (code 9) act on the operand and keep the incoming carry. Half carry is 1 when the low nibble of the result is 0 (increment), or when it is not 0xF (decrement).
- R9: The four rotates (codes 10 to 13) act on the accumulator. The circular forms copy the bit shifted out into carry. The through-carry forms move the old carry into the vacated bit. All other flags are unchanged.
- R10: Pair add (code 17) writes `pair_a`+`pair_b` mod 65536 to `pair_out` and sets carry on overflow beyond 0xFFFF. All other flags are unchanged, and `wr_en`=1.
- R11: Complement (code 14) writes ~A with flags unchanged. Set carry (code 15) and complement carry (code 16) change only carry and have `wr_en`=0.
- R12: `flags_out` bit 1 is 1 and bits 3 and 5 are 0, whatever value `flags_in` carries in those positions.
- R13: An undefined code returns the accumulator, passes the flags through unchanged and has `wr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Capture strobe for one operation |
| op_code | input | 5 | Operation selector |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand / increment-decrement source |
| flags_in | input | 8 | Incoming packed flag byte |
| pair_a | input | 16 | First register pair for pair add |
| pair_b | input | 16 | Second register pair for pair add |
| res_out | output | 8 | Registered result byte |
| pair_out | output | 16 | Registered pair-add result |
| flags_out | output | 8 | Registered packed flag byte |
| wr_en | output | 1 | Destination write-enable, one cycle |
| done | output | 1 | Result registers updated last edge |

## Verification
Reset and a capture strobe can land on the same edge. The bench raises `op_valid` with an add pending while `rst` is high, and then checks that every output holds its reset value. The half-carry tables and the carry chain interact within a single operation. The vector table therefore sets up each case so that a nibble carry, a byte carry, or both, arise from one input pair, and each resulting flag bit is judged against values worked out by hand from the tables.

// File: rtl/balu_pkg.sv
package balu_pkg;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
        OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
        OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
        OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_STC = 5'd15,
        OP_CMC = 5'd16, OP_DAD = 5'd17
    } balu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic c;
    } balu_flags_t;

    // bit k of each table is entry k, indexed by {a[h], b[h], r[h]}
    localparam logic [7:0] HC_ADD_TBL = 8'b1101_0100;
    localparam logic [7:0] HC_SUB_TBL = 8'b1000_1110;

    function automatic logic [7:0] flags_pack(balu_flags_t f);
        return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.c};
    endfunction

    function automatic balu_flags_t flags_unpack(logic [7:0] b);
        balu_flags_t f;
        f.s  = b[7];
        f.z  = b[6];
        f.ac = b[4];
        f.p  = b[2];
        f.c  = b[0];
        return f;
    endfunction

    function automatic logic is_arith(balu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBB) || (op == OP_CMP) || (op == OP_INC) ||
               (op == OP_DEC) || (op == OP_DAD);
    endfunction

endpackage

// File: rtl/balu_arith.sv
module balu_arith
    import balu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  balu_op_e                op,
    input  logic [DATA_W-1:0]       a,
    input  logic [DATA_W-1:0]       b,
    input  balu_flags_t             fin,
    input  logic [2*DATA_W-1:0]     pa,
    input  logic [2*DATA_W-1:0]     pb,
    output logic [DATA_W-1:0]       res,
    output balu_flags_t             fl,
    output logic                    wr,
    output logic [2*DATA_W-1:0]     pair_res
);
    localparam int HB     = DATA_W/2 - 1;
    localparam int PAIR_W = 2*DATA_W;

    logic              cin_add, cin_sub;
    logic [DATA_W:0]   sum9, dif9;
    logic [2:0]        idx_add, idx_sub;
    logic [DATA_W-1:0] inc_r, dec_r, szp_src;
    logic [PAIR_W:0]   pair_sum;

    always_comb begin
        cin_add  = (op == OP_ADC) & fin.c;
        cin_sub  = (op == OP_SBB) & fin.c;
        sum9     = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin_add};
        dif9     = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin_sub};
        idx_add  = {a[HB], b[HB], sum9[HB]};
        idx_sub  = {a[HB], b[HB], dif9[HB]};
        inc_r    = b + 1'b1;
        dec_r    = b - 1'b1;
        pair_sum = {1'b0, pa} + {1'b0, pb};
    end

    always_comb begin
        res      = a;
        fl       = fin;
        wr       = 1'b0;
        pair_res = pair_sum[PAIR_W-1:0];
        szp_src  = a;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res     = sum9[DATA_W-1:0];
                szp_src = sum9[DATA_W-1:0];
                fl.c    = sum9[DATA_W];
                fl.ac   = HC_ADD_TBL[idx_add];
                wr      = 1'b1;
            end
            OP_SUB, OP_SBB: begin
                res     = dif9[DATA_W-1:0];
                szp_src = dif9[DATA_W-1:0];
                fl.c    = dif9[DATA_W];
                fl.ac   = ~HC_SUB_TBL[idx_sub];
                wr      = 1'b1;
            end
            OP_CMP: begin
                szp_src = dif9[DATA_W-1:0];
                fl.c    = dif9[DATA_W];
                fl.ac   = ~HC_SUB_TBL[idx_sub];
            end
            OP_INC: begin
                res     = inc_r;
                szp_src = inc_r;
                fl.ac   = (inc_r[3:0] == 4'h0);
                wr      = 1'b1;
            end
            OP_DEC: begin
                res     = dec_r;
                szp_src = dec_r;
                fl.ac   = (dec_r[3:0] != 4'hF);
                wr      = 1'b1;
            end
            OP_DAD: begin
                fl.c = pair_sum[PAIR_W];
                wr   = 1'b1;
            end
            default: ;
        endcase
        if (op != OP_DAD) begin
            fl.s = szp_src[DATA_W-1];
            fl.z = (szp_src == '0);
            fl.p = ~^szp_src;
        end
    end

endmodule

// File: rtl/balu_bitops.sv
module balu_bitops
    import balu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  balu_op_e          op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  balu_flags_t       fin,
    output logic [DATA_W-1:0] res,
    output balu_flags_t       fl,
    output logic              wr
);
    localparam int HB = DATA_W/2 - 1;

    logic [DATA_W-1:0] lg;
    logic              lg_op;

    always_comb begin
        res   = a;
        fl    = fin;
        wr    = 1'b0;
        lg    = a;
        lg_op = 1'b0;
        unique case (op)
            OP_AND: begin
                lg    = a & b;
                lg_op = 1'b1;
                fl.ac = a[HB] | b[HB];
            end
            OP_OR: begin
                lg    = a | b;
                lg_op = 1'b1;
                fl.ac = 1'b0;
            end
            OP_XOR: begin
                lg    = a ^ b;
                lg_op = 1'b1;
                fl.ac = 1'b0;
            end
            OP_RLC: begin
                res  = {a[DATA_W-2:0], a[DATA_W-1]};
                fl.c = a[DATA_W-1];
                wr   = 1'b1;
            end
            OP_RRC: begin
                res  = {a[0], a[DATA_W-1:1]};
                fl.c = a[0];
                wr   = 1'b1;
            end
            OP_RAL: begin
                res  = {a[DATA_W-2:0], fin.c};
                fl.c = a[DATA_W-1];
                wr   = 1'b1;
            end
            OP_RAR: begin
                res  = {fin.c, a[DATA_W-1:1]};
                fl.c = a[0];
                wr   = 1'b1;
            end
            OP_CMA: begin
                res = ~a;
                wr  = 1'b1;
            end
            OP_STC: fl.c = 1'b1;
            OP_CMC: fl.c = ~fin.c;
            default: ;
        endcase
        if (lg_op) begin
            res  = lg;
            wr   = 1'b1;
            fl.c = 1'b0;
            fl.s = lg[DATA_W-1];
            fl.z = (lg == '0);
            fl.p = ~^lg;
        end
    end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import balu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [4:0]          op_code,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic [DATA_W-1:0]   opnd_in,
    input  logic [7:0]          flags_in,
    input  logic [2*DATA_W-1:0] pair_a,
    input  logic [2*DATA_W-1:0] pair_b,
    output logic [DATA_W-1:0]   res_out,
    output logic [2*DATA_W-1:0] pair_out,
    output logic [7:0]          flags_out,
    output logic                wr_en,
    output logic                done
);
    localparam int PAIR_W = 2*DATA_W;

    balu_op_e          op;
    balu_flags_t       fin, fl_ar, fl_bo, fl_nx, fl_q;
    logic [DATA_W-1:0] res_ar, res_bo, res_nx;
    logic [PAIR_W-1:0] pair_ar;
    logic              wr_ar, wr_bo, wr_nx;

    assign op  = balu_op_e'(op_code);
    assign fin = flags_unpack(flags_in);

    balu_arith #(.DATA_W(DATA_W)) u_arith (
        .op(op), .a(acc_in), .b(opnd_in), .fin(fin),
        .pa(pair_a), .pb(pair_b),
        .res(res_ar), .fl(fl_ar), .wr(wr_ar), .pair_res(pair_ar)
    );

    balu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op(op), .a(acc_in), .b(opnd_in), .fin(fin),
        .res(res_bo), .fl(fl_bo), .wr(wr_bo)
    );

    always_comb begin
        if (is_arith(op)) begin
            res_nx = res_ar;
            fl_nx  = fl_ar;
            wr_nx  = wr_ar;
        end else begin
            res_nx = res_bo;
            fl_nx  = fl_bo;
            wr_nx  = wr_bo;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_out  <= '0;
            pair_out <= '0;
            fl_q     <= '0;
            wr_en    <= 1'b0;
            done     <= 1'b0;
        end else begin
            done  <= op_valid;
            wr_en <= op_valid & wr_nx;
            if (op_valid) begin
                res_out <= res_nx;
                fl_q    <= fl_nx;
                if (op == OP_DAD) pair_out <= pair_ar;
            end
        end
    end

    assign flags_out = flags_pack(fl_q);

    // R12: fixed flag-byte positions
    a_r12_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        flags_out[1] && !flags_out[3] && !flags_out[5]);

    // R2: done follows a strobe by one cycle
    a_r2_done_follows: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> done);

    // R2: write-enable only in the done cycle
    a_r2_wr_in_done: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> done);

    // R2: outputs hold without a strobe
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(res_out) && $stable(flags_out)));

    // R5: compare keeps the accumulator and never writes
    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 5'd4) |=> (!wr_en && res_out == $past(acc_in)));

    // R8: increment and decrement keep carry
    a_r8_keep_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 5'd8 || op_code == 5'd9))
            |=> (flags_out[0] == $past(flags_in[0])));

    // R11: complement leaves every flag alone
    a_r11_cma_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 5'd14)
            |=> (flags_out == (($past(flags_in) & 8'hD5) | 8'h02)));

endmodule

// File: tb/byte_alu_test.sv
module byte_alu_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [4:0]  op_code;
    logic [7:0]  acc_in, opnd_in, flags_in;
    logic [15:0] pair_a, pair_b;
    logic [7:0]  res_out, flags_out;
    logic [15:0] pair_out;
    logic        wr_en, done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    byte_alu uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
        .pair_a(pair_a), .pair_b(pair_b),
        .res_out(res_out), .pair_out(pair_out), .flags_out(flags_out),
        .wr_en(wr_en), .done(done)
    );

    // {op, acc, opnd, flags_in, exp_res, exp_flags, exp_wr}
    localparam int NV = 25;
    localparam logic [45:0] VEC [NV] = '{
        {5'd0,  8'h3A, 8'h0C, 8'h02, 8'h46, 8'h12, 1'b1},
        {5'd0,  8'hFF, 8'h01, 8'h02, 8'h00, 8'h57, 1'b1},
        {5'd1,  8'h10, 8'h20, 8'h03, 8'h31, 8'h02, 1'b1},
        {5'd2,  8'h10, 8'h01, 8'h02, 8'h0F, 8'h06, 1'b1},
        {5'd2,  8'h05, 8'h07, 8'h02, 8'hFE, 8'h83, 1'b1},
        {5'd3,  8'h05, 8'h04, 8'h03, 8'h00, 8'h56, 1'b1},
        {5'd4,  8'h42, 8'h42, 8'h02, 8'h42, 8'h56, 1'b0},
        {5'd4,  8'h20, 8'h30, 8'h02, 8'h20, 8'h97, 1'b0},
        {5'd5,  8'h0F, 8'hF0, 8'h03, 8'h00, 8'h56, 1'b1},
        {5'd5,  8'hF0, 8'hF0, 8'h13, 8'hF0, 8'h86, 1'b1},
        {5'd6,  8'h81, 8'h02, 8'h13, 8'h83, 8'h82, 1'b1},
        {5'd7,  8'h55, 8'h55, 8'h11, 8'h00, 8'h46, 1'b1},
        {5'd8,  8'h00, 8'h0F, 8'h01, 8'h10, 8'h13, 1'b1},
        {5'd8,  8'h00, 8'hFF, 8'h00, 8'h00, 8'h56, 1'b1},
        {5'd9,  8'h00, 8'h10, 8'h01, 8'h0F, 8'h07, 1'b1},
        {5'd9,  8'h00, 8'h01, 8'h00, 8'h00, 8'h56, 1'b1},
        {5'd10, 8'h81, 8'h00, 8'h02, 8'h03, 8'h03, 1'b1},
        {5'd11, 8'h01, 8'h00, 8'hC6, 8'h80, 8'hC7, 1'b1},
        {5'd12, 8'h80, 8'h00, 8'h02, 8'h00, 8'h03, 1'b1},
        {5'd13, 8'h02, 8'h00, 8'h03, 8'h81, 8'h02, 1'b1},
        {5'd14, 8'h5A, 8'h00, 8'h97, 8'hA5, 8'h97, 1'b1},
        {5'd15, 8'h33, 8'h00, 8'h02, 8'h33, 8'h03, 1'b0},
        {5'd16, 8'h44, 8'h00, 8'h03, 8'h44, 8'h02, 1'b0},
        {5'd31, 8'h11, 8'h00, 8'hD7, 8'h11, 8'hD7, 1'b0},
        {5'd14, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hD7, 1'b1}
    };

    function automatic string tag_of(logic [4:0] op);
        case (op)
            5'd0, 5'd1:               return "R3";
            5'd2, 5'd3:               return "R4";
            5'd4:                     return "R5";
            5'd5, 5'd6, 5'd7:         return "R7";
            5'd8, 5'd9:               return "R8";
            5'd10, 5'd11, 5'd12, 5'd13: return "R9";
            5'd14, 5'd15, 5'd16:      return "R11";
            default:                  return "R13";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] f);
        @(negedge clk);
        op_code  = op;
        acc_in   = a;
        opnd_in  = b;
        flags_in = f;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = 5'd0;
        acc_in = 8'h00; opnd_in = 8'h00; flags_in = 8'h00;
        pair_a = 16'h0000; pair_b = 16'h0000;
        repeat (3) @(negedge clk);

        // R1: reset state
        check("R1 reset", {res_out, flags_out, wr_en, done}, {8'h00, 8'h02, 1'b0, 1'b0});
        check("R1 pair reset", pair_out, 16'h0000);

        // R1: strobe together with reset is ignored
        acc_in = 8'h12; opnd_in = 8'h34; flags_in = 8'h00; op_code = 5'd0; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check("R1 reset wins", {res_out, flags_out, wr_en, done}, {8'h00, 8'h02, 1'b0, 1'b0});
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][45:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24:17]);
            check(tag_of(VEC[i][45:41]), {res_out, flags_out, wr_en},
                  {VEC[i][16:9], VEC[i][8:1], VEC[i][0]});
            check("R12 fixed bits", {flags_out[5], flags_out[3], flags_out[1]}, 3'b001);
            check("R2 done", done, 1'b1);
        end

        // R6: sign/zero/parity on a sign-producing add and an even-parity XOR
        apply(5'd0, 8'h7F, 8'h01, 8'h02);
        check("R6 add 7F+01", {res_out, flags_out}, {8'h80, 8'h92});
        apply(5'd7, 8'h03, 8'h00, 8'h02);
        check("R6 xor parity", {res_out, flags_out}, {8'h03, 8'h06});

        // R10: pair add with overflow, then without
        pair_a = 16'hFFFF; pair_b = 16'h0001;
        apply(5'd17, 8'h9A, 8'h00, 8'hC6);
        check("R10 pair overflow", {pair_out, flags_out, wr_en}, {16'h0000, 8'hC7, 1'b1});
        pair_a = 16'h1234; pair_b = 16'h1111;
        apply(5'd17, 8'h9A, 8'h00, 8'h03);
        check("R10 pair plain", {pair_out, flags_out}, {16'h2345, 8'h02});

        // R2: outputs hold without a strobe while inputs move
        apply(5'd0, 8'h01, 8'h02, 8'h02);
        acc_in = 8'hEE; opnd_in = 8'hEE; flags_in = 8'hFF; op_code = 5'd2;
        repeat (3) @(negedge clk);
        check("R2 hold", {res_out, flags_out, wr_en, done}, {8'h03, 8'h06, 1'b0, 1'b0});

        summary();
    end

endmodule